// File: doc/BRIEF.md
# Multicycle FP Issue Interlock

This block is the issue control of a decode stage that feeds four execution units: a one-cycle integer unit, a pipelined multiplier, a pipelined adder and a divider that accepts only one operation at a time. Each cycle it looks at the instruction held in decode and decides whether that instruction may leave decode. If it may not, the block reports every reason that applies. The reasons are a busy divider, a clash on the single result-write port, a source that is not yet ready, or a destination that an older, slower instruction has still to write.

The block keeps one record for each future cycle of the shared memory/write-back path. These records form a shift register that moves one step toward that path every cycle. A record holds the write-port claim together with the destination tag of the instruction that will be in the memory stage in that cycle. The position of a record gives its distance to the memory stage. This distance is enough to stall a consumer. It is also enough to pick the pipeline register that forwards each source operand once the consumer may issue. Integer and FP registers sit in separate files, and a tag only matches a register in its own file.

Top module: `fp_issue_interlock`

## Requirements
- R1: After reset no write-port claim, destination tag or divider occupancy is held. The first valid instruction of any class issues at once with both forward selects at 0.
- R2: An instruction issued in cycle t is in the memory stage in cycle t+L. L is INT_EX+1 for class 0 (integer), MUL_ST+1 for class 1 (multiply), ADD_ST+1 for class 2 (add) and DIV_LAT+1 for class 3 (divide).
- R3: An instruction whose memory-stage cycle equals that of an instruction already issued does not issue. Stall bit 1 is set in each such cycle.
- R4: A divide does not issue until DIV_LAT cycles have passed since the previous divide issued. Stall bit 0 is set meanwhile.
- R5: A source whose youngest in-flight producer is two or more cycles from the memory stage holds the instruction in decode, with stall bit 3 set. A source is matched on the same file and the same register, and only against producers that write.
- R6: The forward select of each source is taken from its youngest matching producer. If that producer is one cycle from the memory stage, the code names its unit: 1 integer, 2 adder, 3 multiplier, 4 divider. If the producer is in the memory stage, the code is 5. Otherwise the code is 0.
- R7: A writing instruction is held in decode, with stall bit 2 set, while an in-flight writer of the same register in the same file will reach the memory stage no earlier than the new instruction would.
- R8: A destination or producer in the integer file never matches a register of the same number in the FP file, for either hazard check.
- R9: While decode holds no valid instruction, issue and all stall bits are 0 and the forward selects are 0. Nothing is claimed: no write-port slot and no divider occupancy.
- R10: Issue is 1 exactly when decode is valid and all four stall bits are 0. Several stall bits may be set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_cls | input | 2 | Class: 0 integer, 1 multiply, 2 add, 3 divide |
| dec_wr_en | input | 1 | Instruction writes a destination register |
| dec_dst_fp | input | 1 | Destination is in the FP file |
| dec_dst | input | REG_W | Destination register number |
| dec_s1_en | input | 1 | First source is read |
| dec_s1_fp | input | 1 | First source is in the FP file |
| dec_s1 | input | REG_W | First source register number |
| dec_s2_en | input | 1 | Second source is read |
| dec_s2_fp | input | 1 | Second source is in the FP file |
| dec_s2 | input | REG_W | Second source register number |
| issue | output | 1 | Instruction leaves decode at this clock edge |
| stall_why | output | 4 | Bit 0 divider busy, bit 1 write-port clash, bit 2 write order, bit 3 source not ready |
| fwd_s1 | output | 3 | Forward select for the first source |
| fwd_s2 | output | 3 | Forward select for the second source |

## Verification
The bench uses DIV_LAT=10 and keeps the default multiply and add depths. With these values the memory-stage distances are 2, 5, 8 and 11 for the four classes. The divider is then still the longest unit, and a full divide occupancy and its dependent stall fit in a few tens of cycles. These values put exact stall counts within reach for every class. They also reach every one of the unit-specific forward codes, and a multiply followed by an add whose memory-stage cycles collide.

// File: rtl/fii_pkg.sv
// Shared types for the issue interlock.
// Assumes two-bit class codes fixed by the decode stage.
package fii_pkg;

    typedef enum logic [1:0] {
        CLS_INT = 2'd0,
        CLS_MUL = 2'd1,
        CLS_ADD = 2'd2,
        CLS_DIV = 2'd3
    } op_cls_e;

    typedef enum logic [2:0] {
        FWD_NONE    = 3'd0,
        FWD_EX_MEM  = 3'd1,
        FWD_ADD_MEM = 3'd2,
        FWD_MUL_MEM = 3'd3,
        FWD_DIV_MEM = 3'd4,
        FWD_MEM_WB  = 3'd5
    } fwd_src_e;

    // One record per future memory-stage cycle.
    typedef struct packed {
        logic    busy;   // write port claimed in this cycle
        logic    wr;     // the claimant writes a register
        logic    fp;     // destination file: 1 = FP
        op_cls_e cls;    // unit that produces the value
    } tag_hdr_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fii_tag_ring.sv
// Write-port reservation shift register with destination tags.
// Slot k describes the instruction that will be in the memory stage
// k cycles from now. Every cycle each slot moves one step toward 0.
// A new claim lands in slot set_idx (its distance minus one, since it is
// written at the same edge as the shift).
// Assumes the caller never claims a slot whose upper neighbour is busy.
module fii_tag_ring
    import fii_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int DEPTH = 26,
    parameter int IDX_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [IDX_W-1:0]            set_idx,
    input  tag_hdr_t                    set_hdr,
    input  logic [REG_W-1:0]            set_dst,
    output tag_hdr_t [DEPTH-1:0]        hdr,
    output logic [DEPTH-1:0][REG_W-1:0] dst
);

    tag_hdr_t [DEPTH-1:0]        hdr_nx;
    logic [DEPTH-1:0][REG_W-1:0] dst_nx;

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        tag_hdr_t         up_hdr;
        logic [REG_W-1:0] up_dst;

        if (k == DEPTH - 1) begin : g_top
            assign up_hdr = '0;
            assign up_dst = '0;
        end else begin : g_mid
            assign up_hdr = hdr[k+1];
            assign up_dst = dst[k+1];
        end

        // Next value: a fresh claim or the record one step further out.
        assign hdr_nx[k] = (set_en && set_idx == IDX_W'(k)) ? set_hdr : up_hdr;
        assign dst_nx[k] = (set_en && set_idx == IDX_W'(k)) ? set_dst : up_dst;

        if (k < DEPTH - 1) begin : g_chk
            // R3: a claim moves forward each cycle and is never overwritten.
            p_claim_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
                hdr[k+1].busy |=> hdr[k].busy);
        end
    end

    // Register the whole ring at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr <= '0;
            dst <= '0;
        end else begin
            hdr <= hdr_nx;
            dst <= dst_nx;
        end
    end

    // R3: every accepted claim is visible in the next cycle.
    p_claim_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> hdr[$past(set_idx)].busy);

endmodule

// File: rtl/fii_div_busy.sv
// Occupancy timer of the divider, which accepts only one operation at a time.
// After a start, busy stays high for DIV_LAT-1 cycles, so the next start
// can come DIV_LAT cycles after the previous one.
// Assumes start is only raised while busy is low.
module fii_div_busy #(
    parameter int DIV_LAT = 24,
    parameter int CNT_W   = $clog2(DIV_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    logic [CNT_W-1:0] cnt;

    // Count down the cycles the divider stays occupied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(DIV_LAT - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    // R4: no second start while occupied.
    p_div_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);

    if (DIV_LAT > 1) begin : g_busy_chk
        // R4: a start always occupies the divider in the next cycle.
        p_div_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> busy);
    end

endmodule

// File: rtl/fii_src_match.sv
// Source readiness and forward selection for one operand.
// It finds the youngest in-flight producer of the register, which is the
// matching slot farthest from the memory stage. It stalls when that
// producer is two or more cycles out. Otherwise it names the pipeline
// register that holds the value when the consumer executes.
// Assumes slot distance 1 means the producer is in its last execute stage.
module fii_src_match
    import fii_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int DEPTH = 26,
    parameter int IDX_W = 5
) (
    input  logic                        en,
    input  logic                        fp,
    input  logic [REG_W-1:0]            src,
    input  tag_hdr_t [DEPTH-1:0]        hdr,
    input  logic [DEPTH-1:0][REG_W-1:0] dst,
    output logic                        raw,
    output fwd_src_e                    fwd
);

    logic             hit;
    logic [IDX_W-1:0] hk;
    op_cls_e          hc;

    // Scan upward so the farthest (youngest) match is kept.
    always_comb begin
        hit = 1'b0;
        hk  = '0;
        hc  = CLS_INT;
        for (int k = 0; k < DEPTH; k++) begin
            if (en && hdr[k].busy && hdr[k].wr &&
                hdr[k].fp == fp && dst[k] == src) begin
                hit = 1'b1;
                hk  = IDX_W'(k);
                hc  = hdr[k].cls;
            end
        end
    end

    // Decide stall and forward source from the producer distance.
    always_comb begin
        raw = hit && (hk >= IDX_W'(2));
        fwd = FWD_NONE;
        if (hit && hk == '0) begin
            fwd = FWD_MEM_WB;
        end else if (hit && hk == IDX_W'(1)) begin
            unique case (hc)
                CLS_INT: fwd = FWD_EX_MEM;
                CLS_ADD: fwd = FWD_ADD_MEM;
                CLS_MUL: fwd = FWD_MUL_MEM;
                CLS_DIV: fwd = FWD_DIV_MEM;
                default: fwd = FWD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/fp_issue_interlock.sv
// Decode-stage issue interlock for integer, multiply, add and divide units.
// It checks four conditions: divider occupancy, the memory-stage cycle
// against the reservation ring, the write order against older writers of
// the same register, and source readiness. It reports each one on its own
// stall bit and issues only when none holds.
// Assumes one shared memory/write-back path and separate register files.
module fp_issue_interlock
    import fii_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int INT_EX  = 1,
    parameter int MUL_ST  = 7,
    parameter int ADD_ST  = 4,
    parameter int DIV_LAT = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [1:0]       dec_cls,
    input  logic             dec_wr_en,
    input  logic             dec_dst_fp,
    input  logic [REG_W-1:0] dec_dst,
    input  logic             dec_s1_en,
    input  logic             dec_s1_fp,
    input  logic [REG_W-1:0] dec_s1,
    input  logic             dec_s2_en,
    input  logic             dec_s2_fp,
    input  logic [REG_W-1:0] dec_s2,
    output logic             issue,
    output logic [3:0]       stall_why,
    output logic [2:0]       fwd_s1,
    output logic [2:0]       fwd_s2
);

    localparam int INT_OFF = INT_EX + 1;
    localparam int MUL_OFF = MUL_ST + 1;
    localparam int ADD_OFF = ADD_ST + 1;
    localparam int DIV_OFF = DIV_LAT + 1;
    localparam int MAX_OFF = max2(max2(INT_OFF, MUL_OFF), max2(ADD_OFF, DIV_OFF));
    localparam int DEPTH   = MAX_OFF + 1;
    localparam int IDX_W   = $clog2(DEPTH);

    op_cls_e                     cls;
    logic [IDX_W-1:0]            off;
    tag_hdr_t [DEPTH-1:0]        hdr;
    logic [DEPTH-1:0][REG_W-1:0] dst;
    logic [DEPTH-1:0]            waw_hit;
    logic                        div_busy;
    logic                        why_div, why_port, why_waw, why_raw;
    logic                        raw1, raw2;
    fwd_src_e                    fwd1, fwd2;
    tag_hdr_t                    new_hdr;

    assign cls = op_cls_e'(dec_cls);

    // Distance from issue to the memory stage for the decoded class.
    always_comb begin
        unique case (cls)
            CLS_INT: off = IDX_W'(INT_OFF);
            CLS_MUL: off = IDX_W'(MUL_OFF);
            CLS_ADD: off = IDX_W'(ADD_OFF);
            CLS_DIV: off = IDX_W'(DIV_OFF);
            default: off = IDX_W'(INT_OFF);
        endcase
    end

    fii_tag_ring #(
        .REG_W (REG_W),
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) ring_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (issue),
        .set_idx (off - IDX_W'(1)),
        .set_hdr (new_hdr),
        .set_dst (dec_dst),
        .hdr     (hdr),
        .dst     (dst)
    );

    fii_div_busy #(
        .DIV_LAT (DIV_LAT)
    ) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (issue && cls == CLS_DIV),
        .busy  (div_busy)
    );

    fii_src_match #(
        .REG_W (REG_W),
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) src1_i (
        .en  (dec_s1_en),
        .fp  (dec_s1_fp),
        .src (dec_s1),
        .hdr (hdr),
        .dst (dst),
        .raw (raw1),
        .fwd (fwd1)
    );

    fii_src_match #(
        .REG_W (REG_W),
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) src2_i (
        .en  (dec_s2_en),
        .fp  (dec_s2_fp),
        .src (dec_s2),
        .hdr (hdr),
        .dst (dst),
        .raw (raw2),
        .fwd (fwd2)
    );

    // Older writers of the same register that would finish no earlier.
    for (genvar k = 0; k < DEPTH; k++) begin : g_waw
        assign waw_hit[k] = dec_wr_en && hdr[k].busy && hdr[k].wr &&
                            (hdr[k].fp == dec_dst_fp) && (dst[k] == dec_dst) &&
                            (IDX_W'(k) >= off);
    end

    // Collect stall reasons, each gated by a valid decode slot.
    always_comb begin
        why_div  = dec_valid && (cls == CLS_DIV) && div_busy;
        why_port = dec_valid && hdr[off].busy;
        why_waw  = dec_valid && (|waw_hit);
        why_raw  = dec_valid && (raw1 || raw2);
    end

    assign stall_why = {why_raw, why_waw, why_port, why_div};
    assign issue     = dec_valid && !(why_div || why_port || why_waw || why_raw);

    // Record placed in the ring for the issuing instruction.
    always_comb begin
        new_hdr      = '0;
        new_hdr.busy = 1'b1;
        new_hdr.wr   = dec_wr_en;
        new_hdr.fp   = dec_dst_fp;
        new_hdr.cls  = cls;
    end

    assign fwd_s1 = dec_valid ? fwd1 : FWD_NONE;
    assign fwd_s2 = dec_valid ? fwd2 : FWD_NONE;

    // R5: a not-ready stall always comes from an enabled source.
    p_raw_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_why[3] |-> (dec_s1_en || dec_s2_en));

    // R7: a write-order stall only applies to a writing instruction.
    p_waw_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_why[2] |-> dec_wr_en);

endmodule

// File: tb/fp_issue_interlock_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module fp_issue_interlock_tb_top;
    import fii_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dec_valid, dec_wr_en, dec_dst_fp;
    logic [1:0] dec_cls;
    logic [4:0] dec_dst, dec_s1, dec_s2;
    logic       dec_s1_en, dec_s1_fp, dec_s2_en, dec_s2_fp;
    logic       issue;
    logic [3:0] stall_why;
    logic [2:0] fwd_s1, fwd_s2;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fp_issue_interlock #(.DIV_LAT(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_cls(dec_cls),
        .dec_wr_en(dec_wr_en), .dec_dst_fp(dec_dst_fp), .dec_dst(dec_dst),
        .dec_s1_en(dec_s1_en), .dec_s1_fp(dec_s1_fp), .dec_s1(dec_s1),
        .dec_s2_en(dec_s2_en), .dec_s2_fp(dec_s2_fp), .dec_s2(dec_s2),
        .issue(issue), .stall_why(stall_why), .fwd_s1(fwd_s1), .fwd_s2(fwd_s2)
    );

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Present one instruction from the next falling edge until it issues.
    task automatic send(input op_cls_e c, input logic wr, input logic dfp,
                        input logic [4:0] d,
                        input logic a_en, input logic a_fp, input logic [4:0] a,
                        input logic b_en, input logic b_fp, input logic [4:0] b,
                        output int stalls, output logic [3:0] why0,
                        output logic [2:0] f1, output logic [2:0] f2);
        @(negedge clk);
        dec_valid = 1'b1; dec_cls = c; dec_wr_en = wr; dec_dst_fp = dfp; dec_dst = d;
        dec_s1_en = a_en; dec_s1_fp = a_fp; dec_s1 = a;
        dec_s2_en = b_en; dec_s2_fp = b_fp; dec_s2 = b;
        stalls = 0;
        why0   = 4'd0;
        for (int i = 0; i < 60; i++) begin
            #1;
            if (i == 0) why0 = stall_why;
            if (issue) break;
            stalls++;
            @(negedge clk);
        end
        f1 = fwd_s1;
        f2 = fwd_s2;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        dec_valid = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        int s; logic [3:0] w; logic [2:0] f1, f2;
        @(negedge clk);
        dec_valid = 1'b0; dec_cls = CLS_DIV;
        #1;
        check("R9 idle issue", int'(issue), 0);
        check("R9 idle stall_why", int'(stall_why), 0);
        check("R9 idle fwd_s1", int'(fwd_s1), 0);
        send(CLS_DIV, 1, 1, 5'd3, 1, 1, 5'd1, 1, 1, 5'd2, s, w, f1, f2);
        check("R1 first divide stalls", s, 0);
        check("R1 first fwd_s1", int'(f1), 0);
        check("R1 first fwd_s2", int'(f2), 0);
        idle(16);
    endtask

    task automatic t_int_fwd();
        int s; logic [3:0] w; logic [2:0] f1, f2;
        send(CLS_INT, 1, 0, 5'd3, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_INT, 0, 0, 5'd0, 1, 0, 5'd3, 0, 0, 5'd0, s, w, f1, f2);
        check("R6 int dist1 stalls", s, 0);
        check("R6 int dist1 fwd EX_MEM", int'(f1), 1);
        send(CLS_INT, 0, 0, 5'd0, 1, 0, 5'd3, 0, 0, 5'd0, s, w, f1, f2);
        check("R6 int dist0 fwd MEM_WB", int'(f1), 5);
        send(CLS_INT, 0, 0, 5'd0, 0, 0, 5'd0, 1, 0, 5'd3, s, w, f1, f2);
        check("R6 int retired fwd none", int'(f2), 0);
        idle(4);
    endtask

    task automatic t_youngest();
        int s; logic [3:0] w; logic [2:0] f1, f2;
        send(CLS_INT, 1, 0, 5'd5, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_INT, 1, 0, 5'd5, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        check("R7 in-order int rewrite stalls", s, 0);
        send(CLS_INT, 0, 0, 5'd0, 1, 0, 5'd5, 0, 0, 5'd0, s, w, f1, f2);
        check("R6 youngest producer fwd EX_MEM", int'(f1), 1);
        idle(4);
    endtask

    task automatic t_add_raw();
        int s; logic [3:0] w; logic [2:0] f1, f2;
        send(CLS_ADD, 1, 1, 5'd2, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_ADD, 0, 1, 5'd0, 1, 1, 5'd2, 0, 0, 5'd0, s, w, f1, f2);
        check("R5 add consumer stalls", s, 3);
        check("R10 add consumer reason", int'(w), 8);
        check("R6 add fwd ADD_MEM", int'(f1), 2);
        idle(8);
    endtask

    task automatic t_file();
        int s; logic [3:0] w; logic [2:0] f1, f2;
        send(CLS_ADD, 1, 1, 5'd6, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_INT, 1, 0, 5'd6, 1, 0, 5'd6, 0, 0, 5'd0, s, w, f1, f2);
        check("R8 other file no stall", s, 0);
        check("R8 other file fwd none", int'(f1), 0);
        send(CLS_INT, 0, 0, 5'd0, 1, 1, 5'd6, 0, 0, 5'd0, s, w, f1, f2);
        check("R8 same file stalls", s, 2);
        check("R8 same file fwd ADD_MEM", int'(f1), 2);
        idle(8);
    endtask

    task automatic t_mul_raw();
        int s; logic [3:0] w; logic [2:0] f1, f2;
        send(CLS_MUL, 1, 1, 5'd8, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_ADD, 0, 1, 5'd0, 1, 1, 5'd8, 1, 1, 5'd9, s, w, f1, f2);
        check("R5 mul consumer stalls", s, 6);
        check("R6 mul fwd MUL_MEM", int'(f1), 3);
        check("R6 unrelated source fwd none", int'(f2), 0);
        idle(12);
    endtask

    task automatic t_div();
        int s; logic [3:0] w; logic [2:0] f1, f2;
        send(CLS_DIV, 1, 1, 5'd10, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_DIV, 1, 1, 5'd11, 1, 1, 5'd12, 0, 0, 5'd0, s, w, f1, f2);
        check("R4 second divide stalls", s, 9);
        check("R4 divider reason", int'(w), 1);
        idle(25);
        send(CLS_DIV, 1, 1, 5'd13, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_INT, 0, 0, 5'd0, 1, 1, 5'd13, 0, 0, 5'd0, s, w, f1, f2);
        check("R5 divide consumer stalls", s, 9);
        check("R6 divide fwd DIV_MEM", int'(f1), 4);
        idle(16);
    endtask

    task automatic t_port();
        int s; logic [3:0] w; logic [2:0] f1, f2;
        send(CLS_MUL, 1, 1, 5'd1, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_INT, 0, 0, 5'd0, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_INT, 0, 0, 5'd0, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_ADD, 1, 1, 5'd3, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        check("R3 mul/add clash stalls", s, 1);
        check("R2 mul/add clash reason", int'(w), 2);
        idle(12);
        send(CLS_ADD, 1, 1, 5'd4, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_INT, 0, 0, 5'd0, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_INT, 0, 0, 5'd0, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_INT, 1, 0, 5'd1, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        check("R3 add/int clash stalls", s, 1);
        check("R2 add/int clash reason", int'(w), 2);
        idle(8);
    endtask

    task automatic t_waw();
        int s; logic [3:0] w; logic [2:0] f1, f2;
        send(CLS_MUL, 1, 1, 5'd4, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_ADD, 1, 1, 5'd4, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        check("R7 add behind mul stalls", s, 3);
        check("R7 write-order reason", int'(w), 4);
        idle(12);
        send(CLS_MUL, 1, 1, 5'd7, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        send(CLS_INT, 1, 0, 5'd7, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        check("R8 cross-file write no stall", s, 0);
        idle(12);
    endtask

    task automatic t_idle();
        int s; logic [3:0] w; logic [2:0] f1, f2;
        send(CLS_DIV, 1, 1, 5'd20, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        @(negedge clk);
        dec_valid = 1'b0; dec_cls = CLS_DIV;
        #1;
        check("R9 invalid divide while busy issue", int'(issue), 0);
        check("R9 invalid divide while busy reasons", int'(stall_why), 0);
        idle(16);
        @(negedge clk);
        dec_valid = 1'b0; dec_cls = CLS_DIV;
        send(CLS_DIV, 1, 1, 5'd21, 0, 0, 5'd0, 0, 0, 5'd0, s, w, f1, f2);
        check("R9 invalid divide left divider free", s, 0);
        idle(16);
    endtask

    initial begin
        rst_n = 1'b0; dec_valid = 1'b0; dec_cls = 2'd0; dec_wr_en = 1'b0;
        dec_dst_fp = 1'b0; dec_dst = '0; dec_s1_en = 1'b0; dec_s1_fp = 1'b0;
        dec_s1 = '0; dec_s2_en = 1'b0; dec_s2_fp = 1'b0; dec_s2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_int_fwd();
        t_youngest();
        t_add_raw();
        t_file();
        t_mul_raw();
        t_div();
        t_port();
        t_waw();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule